// File: doc/BRIEF.md
# Address-Folded Check-Code Memory

This block wraps a small word-addressed storage array. Every stored word carries an 8-bit check code. The code is not computed over the data alone. It is computed over the data XORed with the write address. On a load, the block rebuilds the expected code from the word that came back and the address that was asked for. It then compares that code with the code stored beside the word. A mismatch raises an error flag in the same cycle as the returned word.

Because the requested address is part of the comparison, two kinds of fault are caught:
- a corrupted word at the right location;
- an intact word fetched from the wrong location, for example by a broken decoder.

The full address is never kept in the array; only the folded code is.

Correction is not attempted. Two test hooks let a bench create both fault types:
- a read-redirect hook that sends reads of one chosen address to another location;
- a bit-flip hook that XORs a mask into the data of one stored word.

Top module: `addr_edc_mem`

## Requirements
- R1: A write of value D to address A stores D together with the code CRC(D XOR A). A is zero-extended to the data width before the XOR. The address is not stored.
- R2: The code is CRC-8 with generator x^8+x^2+x+1 (0x07), initial value 0, message bits taken MSB first, with no reflection and no final XOR. A consequence follows: flipping stored data by a mask that is a multiple of the generator (for example 16'h0107 or 16'h0838) goes undetected. A mask such as 16'h0106 is flagged.
- R3: A read of an address, with no fault injected since its last write, returns the written value with `rd_err` = 0.
- R4: `rd_valid`, `rd_data` and `rd_err` are valid together exactly one cycle after a cycle with `rd_en` = 1. `rd_valid` is 0 in the cycle after a cycle with `rd_en` = 0. `rd_data` and `rd_err` hold their values while no read is issued.
- R5: A single-bit flip at any data position of a stored word is flagged with `rd_err` = 1 on the next read of that word. The read returns the flipped value.
- R6: When a read of address A is redirected to address B (B differs from A), `rd_data` is the word stored at B and `rd_err` = 1. This holds even if B holds the same value as A.
- R7: A write and a read of the same address in the same cycle return the old word and its old code, so `rd_err` = 0. The new value is returned by later reads.
- R8: The redirect affects only reads whose address equals `inj_remap_from`. Reads of other addresses, and a redirect whose source equals its target, return clean results.
- R9: A bit flip requested on the address being written in the same cycle is ignored, and the written value is stored intact. A flip on a different address in that cycle still applies.
- R10: After reset, `rd_valid`, `rd_data` and `rd_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the read path |
| wr_en | input | 1 | Store request |
| wr_addr | input | ADDR_W | Store address |
| wr_data | input | DATA_W | Store value |
| rd_en | input | 1 | Load request |
| rd_addr | input | ADDR_W | Load address |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | DATA_W | Returned word |
| rd_err | output | 1 | Check-code mismatch for the returned word |
| inj_remap_en | input | 1 | Enable read redirect hook |
| inj_remap_from | input | ADDR_W | Address whose reads are redirected |
| inj_remap_to | input | ADDR_W | Location actually read instead |
| inj_flip_en | input | 1 | Enable stored-data bit flip hook |
| inj_flip_addr | input | ADDR_W | Word to corrupt |
| inj_flip_mask | input | DATA_W | Mask XORed into the stored data |

## Verification
The embedded properties check on every cycle that:
- the result strobe tracks the load request with one cycle of latency;
- outputs hold while idle;
- a store lands in the array with both data and code;
- a same-cycle load of a stored address sees the previous contents.

Whether a mismatch is flagged depends on the arithmetic of the code. That includes the redirected read of an identical value, every single-bit flip, and the undetectable generator-multiple masks. These are shown only by the bench's directed scenarios, which compare every returned word and flag against a scoreboard.

// File: rtl/addr_edc_pkg.sv
package addr_edc_pkg;
   localparam int CODE_W = 8;
   localparam logic [CODE_W-1:0] CRC_POLY = 8'h07;

   // One bit of serial CRC: shift in msg bit b.
   function automatic logic [CODE_W-1:0] crc_bit_step(input logic [CODE_W-1:0] c, input logic b);
      logic fb;
      fb = c[CODE_W-1] ^ b;
      return {c[CODE_W-2:0], 1'b0} ^ (fb ? CRC_POLY : {CODE_W{1'b0}});
   endfunction
endpackage

// File: rtl/aedc_crc8.sv
module aedc_crc8
   import addr_edc_pkg::*;
#(
   parameter int MSG_W = 16
) (
   input  logic [MSG_W-1:0]  msg,
   output logic [CODE_W-1:0] code
);
   if (MSG_W < 1) begin : g_bad_w
      $error("aedc_crc8: MSG_W must be positive");
   end

   always_comb begin
      code = '0;
      for (int i = MSG_W - 1; i >= 0; i--) begin
         code = crc_bit_step(code, msg[i]);
      end
   end
endmodule

// File: rtl/aedc_array.sv
module aedc_array
   import addr_edc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] q_data,
   output logic [CODE_W-1:0] q_code,
   input  logic              flip_en,
   input  logic [ADDR_W-1:0] flip_addr,
   input  logic [DATA_W-1:0] flip_mask
);
   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic [DATA_W-1:0] data;
   } entry_t;

   entry_t mem [DEPTH];
   logic   flip_live;

   // A store to the same word wins over a flip of it.
   assign flip_live = flip_en && !(wr_en && (wr_addr == flip_addr));

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= '{code: wr_code, data: wr_data};
      end
      if (flip_live) begin
         mem[flip_addr].data <= mem[flip_addr].data ^ flip_mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_data <= '0;
         q_code <= '0;
      end else if (rd_en) begin
         q_data <= mem[rd_addr].data;
         q_code <= mem[rd_addr].code;
      end
   end

   // R1, R9: a store lands with its data and code, whatever flip was requested.
   p_store_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem[$past(wr_addr)].data == $past(wr_data)) &&
                (mem[$past(wr_addr)].code == $past(wr_code)));

   // R7: same-cycle load of the stored word sees the previous contents.
   p_read_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en && (rd_addr == wr_addr)) |=>
         (q_data == $past(mem[wr_addr].data)) && (q_code == $past(mem[wr_addr].code)));
endmodule

// File: rtl/addr_edc_mem.sv
module addr_edc_mem
   import addr_edc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err,
   input  logic              inj_remap_en,
   input  logic [ADDR_W-1:0] inj_remap_from,
   input  logic [ADDR_W-1:0] inj_remap_to,
   input  logic              inj_flip_en,
   input  logic [ADDR_W-1:0] inj_flip_addr,
   input  logic [DATA_W-1:0] inj_flip_mask
);
   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("addr_edc_mem: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < ADDR_W || DATA_W < CODE_W) begin : g_bad_width
      $error("addr_edc_mem: DATA_W must cover the address and the code width");
   end

   logic [DATA_W-1:0] wr_addr_ext, req_addr_ext;
   logic [ADDR_W-1:0] req_addr_q, eff_rd_addr;
   logic [CODE_W-1:0] wr_code, exp_code, q_code;
   logic [DATA_W-1:0] q_data;
   logic              valid_q;

   // Zero-extend addresses to the data width before folding.
   if (DATA_W > ADDR_W) begin : g_pad
      assign wr_addr_ext  = {{(DATA_W-ADDR_W){1'b0}}, wr_addr};
      assign req_addr_ext = {{(DATA_W-ADDR_W){1'b0}}, req_addr_q};
   end else begin : g_nopad
      assign wr_addr_ext  = wr_addr;
      assign req_addr_ext = req_addr_q;
   end

   aedc_crc8 #(.MSG_W(DATA_W)) u_wr_crc (
      .msg  (wr_data ^ wr_addr_ext),
      .code (wr_code)
   );

   // Read redirect hook models a faulty decoder.
   assign eff_rd_addr = (inj_remap_en && (rd_addr == inj_remap_from)) ? inj_remap_to : rd_addr;

   aedc_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_code   (wr_code),
      .rd_en     (rd_en),
      .rd_addr   (eff_rd_addr),
      .q_data    (q_data),
      .q_code    (q_code),
      .flip_en   (inj_flip_en),
      .flip_addr (inj_flip_addr),
      .flip_mask (inj_flip_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_addr_q <= '0;
         valid_q    <= 1'b0;
      end else begin
         valid_q <= rd_en;
         if (rd_en) req_addr_q <= rd_addr;
      end
   end

   // Expected code uses the requested address, not the one actually read.
   aedc_crc8 #(.MSG_W(DATA_W)) u_rd_crc (
      .msg  (q_data ^ req_addr_ext),
      .code (exp_code)
   );

   assign rd_valid = valid_q;
   assign rd_data  = q_data;
   assign rd_err   = (exp_code != q_code);

   p_valid_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   p_valid_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
   p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> ($stable(rd_data) && $stable(rd_err)));
   p_reset_quiet_r10: assert property (@(posedge clk)
      !rst_n |-> (!rd_valid && !rd_err && (rd_data == '0)));
endmodule

// File: tb/addr_edc_mem_tb_top.sv
module addr_edc_mem_tb_top;
   localparam int DW = 16;
   localparam int DP = 16;
   localparam int AW = $clog2(DP);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 0, rd_en = 0, inj_remap_en = 0, inj_flip_en = 0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0, inj_remap_from = '0, inj_remap_to = '0, inj_flip_addr = '0;
   logic [DW-1:0] wr_data = '0, inj_flip_mask = '0;
   logic rd_valid, rd_err;
   logic [DW-1:0] rd_data;

   always #5 clk = ~clk;

   addr_edc_mem #(.DATA_W(DW), .DEPTH(DP)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
      .inj_remap_en(inj_remap_en), .inj_remap_from(inj_remap_from), .inj_remap_to(inj_remap_to),
      .inj_flip_en(inj_flip_en), .inj_flip_addr(inj_flip_addr), .inj_flip_mask(inj_flip_mask)
   );

   typedef struct {
      logic [DW-1:0] d;
      logic          e;
      string         tag;
   } exp_t;

   exp_t sb[$];
   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] img [DP];

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] ad, input logic ae,
                        input logic [DW-1:0] ed, input logic ee);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual data=%h err=%0b expected data=%h err=%0b", tag, ad, ae, ed, ee);
      end
   endtask

   // Monitor: pops one expectation per returned word.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && rd_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R4 unexpected rd_valid", rd_data, rd_err, '0, 1'b0);
            end else begin
               exp_t x;
               x = sb.pop_front();
               check((rd_data === x.d) && (rd_err === x.e), x.tag, rd_data, rd_err, x.d, x.e);
            end
         end
      end
   end

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
      img[a] = d;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] ed, input logic ee, input string tag);
      sb.push_back('{d: ed, e: ee, tag: tag});
      rd_en = 1; rd_addr = a;
      @(negedge clk);
      rd_en = 0;
   endtask

   task automatic flip(input logic [AW-1:0] a, input logic [DW-1:0] m);
      inj_flip_en = 1; inj_flip_addr = a; inj_flip_mask = m;
      @(negedge clk);
      inj_flip_en = 0;
      img[a] = img[a] ^ m;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog R4: actual data=%h err=%0b expected data=%h err=%0b", rd_data, rd_err, '0, 1'b0);
      finish_run();
   end

   initial begin
      logic [DW-1:0] d13;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10: reset state.
      check(!rd_valid && !rd_err && rd_data == '0, "R10 reset state", rd_data, rd_err, '0, 1'b0);

      // R1, R3: clean writes then back-to-back reads (R4 latency via monitor).
      for (int i = 0; i < 8; i++) wr(i[AW-1:0], (DW'(i) * 16'h1111) ^ 16'h5A5A);
      wr(15, 16'hFFFF);
      wr(8, 16'h0000);
      for (int i = 0; i < 8; i++) rd(i[AW-1:0], img[i], 1'b0, "R1 R3 clean read");
      rd(15, 16'hFFFF, 1'b0, "R3 all-ones word at top address");
      rd(8, 16'h0000, 1'b0, "R3 zero word");

      // R4: outputs hold while idle.
      idle();
      check(!rd_valid && rd_data == 16'h0000 && !rd_err, "R4 hold when idle", rd_data, rd_err, 16'h0000, 1'b0);
      idle();
      check(!rd_valid && rd_data == 16'h0000, "R4 still holding", rd_data, rd_err, 16'h0000, 1'b0);

      // R7: same-cycle write and read of address 2.
      sb.push_back('{d: img[2], e: 1'b0, tag: "R7 collision returns old"});
      wr_en = 1; wr_addr = 2; wr_data = 16'hBEEF; rd_en = 1; rd_addr = 2;
      @(negedge clk);
      wr_en = 0; rd_en = 0; img[2] = 16'hBEEF;
      rd(2, 16'hBEEF, 1'b0, "R7 new value after collision");

      // R6: redirect to a word holding the same value.
      wr(10, 16'h1234);
      wr(11, 16'h1234);
      inj_remap_en = 1; inj_remap_from = 10; inj_remap_to = 11;
      rd(10, 16'h1234, 1'b1, "R6 redirect same value");
      rd(11, 16'h1234, 1'b0, "R8 target address unaffected");
      rd(3, img[3], 1'b0, "R8 other address unaffected");
      inj_remap_to = 0;
      rd(10, img[0], 1'b1, "R6 redirect different value");
      inj_remap_to = 10;
      rd(10, 16'h1234, 1'b0, "R8 redirect onto itself");
      inj_remap_en = 0; inj_remap_to = 11;
      rd(10, 16'h1234, 1'b0, "R8 redirect disabled");

      // R5: every single-bit flip is flagged.
      for (int b = 0; b < DW; b++) begin
         wr(13, 16'h3C96);
         flip(13, DW'(1) << b);
         rd(13, 16'h3C96 ^ (DW'(1) << b), 1'b1, "R5 single-bit flip");
      end

      // R2: generator multiples alias, a near miss does not.
      wr(13, 16'h3C96);
      d13 = 16'h3C96;
      flip(13, 16'h0107);
      d13 = d13 ^ 16'h0107;
      rd(13, d13, 1'b0, "R2 mask 0107 undetected");
      flip(13, 16'h0838);
      d13 = d13 ^ 16'h0838;
      rd(13, d13, 1'b0, "R2 mask 0838 undetected");
      flip(13, 16'h0106);
      d13 = d13 ^ 16'h0106;
      rd(13, d13, 1'b1, "R2 mask 0106 detected");

      // R9: flip on the word being written is ignored.
      inj_flip_en = 1; inj_flip_addr = 14; inj_flip_mask = 16'h00FF;
      wr(14, 16'h7777);
      inj_flip_en = 0;
      rd(14, 16'h7777, 1'b0, "R9 flip ignored during write");
      inj_flip_en = 1; inj_flip_addr = 5; inj_flip_mask = 16'h0001;
      wr(6, 16'h4242);
      inj_flip_en = 0;
      rd(6, 16'h4242, 1'b0, "R9 written word clean");
      rd(5, img[5] ^ 16'h0001, 1'b1, "R9 flip elsewhere applies");

      idle();
      idle();
      check(sb.size() == 0 && !rd_valid, "R4 every read answered", rd_data, rd_err, '0, 1'b0);
      finish_run();
   end
endmodule